// File: doc/BRIEF.md
# Burst Address Order Sequencer

The sequencer generates the word-address stream for one memory burst on a parallel bus that is 32 or 64 bits wide. A `load` pulse captures the start word address, the burst order, the cache-line size in words, the bus width and a coherency flag. From the next cycle the current byte address appears on `addr`. Each completed data phase (`phase_done`) moves the address one step. A step is one word on a narrow bus and two words (one doubleword) on a wide bus. The byte enables of a data phase are not an input, so a phase with no bytes enabled still advances the address like any other phase.

Three orders are offered. Linear counts upward. Toggle XORs a running word count into the start address. Wrap climbs through the current cache line, wraps back to the line's base, and after a whole line continues in the next line at the same offset. The block raises `disconnect` on the data phase that must be the last of the burst. That is the final phase before a cache-line crossing when the burst is coherent, or the first phase when the programmed line size cannot be used. After that phase the burst ends.

Top module: `burst_addr_seq`

## Requirements
- R1: After reset, `addr` is 0 and `active`, `disconnect`, `single_only` and `align_err` are all 0.
- R2: In the cycle after `load`, `addr` equals `start_word` times 4 and `active` is 1, unless R9 applies. A load during a running burst restarts it.
- R3: In linear order (`order_mode` 2'b00) each phase raises `addr` by 4 bytes, or by 8 bytes when `wide` is 1.
- R4: In toggle order (`order_mode` 2'b01) the word address after k words equals the start word XOR k. k grows by 1 per phase, or by 2 per phase when wide.
- R5: In wrap order (`order_mode` 2'b10) the word offset within the line advances modulo the line size. After every full line the address moves to the next line at the same start offset.
- R6: Line sizes of 4, 8 and 16 words are supported. Any other `line_words` value sets `single_only`, holds `disconnect` high from the first phase, and ends the burst after one phase with `addr` unchanged.
- R7: With `coherent` set in linear order, `disconnect` is high on the phase at the last word of a line (the last doubleword when wide). That phase ends the burst: `active` falls and `addr` holds.
- R8: With `coherent` set in toggle or wrap order, `disconnect` is high on the phase that completes the burst's first line worth of words.
- R9: A wide load with `start_word` bit 0 set, which is not doubleword aligned, sets `align_err` and leaves `active` at 0.
- R10: `addr` changes only on a `phase_done` during an active burst, or on a load.
- R11: `order_mode` 2'b11 behaves as linear order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| load | input | 1 | Capture a new burst set-up |
| start_word | input | 30 | Start address in 32-bit words |
| order_mode | input | 2 | 00 linear, 01 toggle, 10 wrap, 11 linear |
| line_words | input | 8 | Cache-line size in words |
| wide | input | 1 | 1 = 64-bit bus, two words per phase |
| coherent | input | 1 | Stop the burst at a cache-line boundary |
| phase_done | input | 1 | A data phase completed this cycle |
| addr | output | 32 | Current byte address, low two bits zero |
| active | output | 1 | Burst in progress |
| disconnect | output | 1 | The current phase must be the last one |
| single_only | output | 1 | Line size unsupported, single-word transfers only |
| align_err | output | 1 | Wide burst start was not doubleword aligned |

## Verification
The hardest situation to reach is the second pass of a wrap burst, where the address must jump into the next line at the original offset rather than at the line base. The stimulus gets there by loading a start offset in the middle of a line and then issuing exactly one line worth of phases, so the check samples the first address of the second line. A second hard case is the end of a coherent burst when the start is not line-aligned. Here the stimulus loads an offset one word into a line and counts phases up to the boundary, then checks that the address holds once `active` has fallen.

// File: rtl/bseq_pkg.sv
package bseq_pkg;
  // Burst order encoding; code 3 aliases linear (R11)
  typedef enum logic [1:0] {
    ORD_LINEAR     = 2'b00,
    ORD_TOGGLE     = 2'b01,
    ORD_WRAP       = 2'b10,
    ORD_LINEAR_ALT = 2'b11
  } order_e;
endpackage

// File: rtl/bseq_line_decode.sv
module bseq_line_decode #(
  parameter int unsigned CFG_W    = 8,
  parameter int unsigned WORD_W   = 30,
  parameter int unsigned MIN_LINE = 4,
  parameter int unsigned N_SIZES  = 3
) (
  input  logic [CFG_W-1:0]  line_words,
  output logic [WORD_W-1:0] line_mask,
  output logic              supported
);
  // Supported sizes are MIN_LINE << k for k < N_SIZES (R6)
  always_comb begin
    supported = 1'b0;
    line_mask = '0;
    for (int k = 0; k < N_SIZES; k++) begin
      if (line_words == CFG_W'(MIN_LINE << k)) begin
        supported = 1'b1;
        line_mask = WORD_W'((MIN_LINE << k) - 1);
      end
    end
  end
endmodule

// File: rtl/bseq_phase_counter.sv
module bseq_phase_counter #(
  parameter int unsigned W = 30
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         step_en,
  input  logic         step_two,
  output logic [W-1:0] count
);
  localparam logic [W-1:0] ONE = W'(1);
  localparam logic [W-1:0] TWO = W'(2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       count <= '0;
    else if (clear)   count <= '0;
    else if (step_en) count <= count + (step_two ? TWO : ONE);
  end
endmodule

// File: rtl/bseq_addr_calc.sv
module bseq_addr_calc
  import bseq_pkg::*;
#(
  parameter int unsigned WORD_W = 30
) (
  input  logic [WORD_W-1:0] base_word,
  input  logic [WORD_W-1:0] count,
  input  logic [WORD_W-1:0] line_mask,
  input  order_e            mode,
  input  logic              wide,
  output logic [WORD_W-1:0] word_addr,
  output logic              at_last
);
  function automatic logic [WORD_W-1:0] f_linear(logic [WORD_W-1:0] b, logic [WORD_W-1:0] c);
    return b + c;
  endfunction

  function automatic logic [WORD_W-1:0] f_toggle(logic [WORD_W-1:0] b, logic [WORD_W-1:0] c);
    return b ^ c;
  endfunction

  // line base + whole lines done + offset modulo line
  function automatic logic [WORD_W-1:0] f_wrap(logic [WORD_W-1:0] b, logic [WORD_W-1:0] c,
                                               logic [WORD_W-1:0] m);
    return (b & ~m) + (c & ~m) + ((b + c) & m);
  endfunction

  logic [WORD_W-1:0] last_off;
  logic              lin_last;
  logic              blk_last;

  assign last_off = line_mask - (wide ? WORD_W'(1) : WORD_W'(0));
  assign lin_last = ((base_word + count) & line_mask) == last_off;
  assign blk_last = (count & line_mask) == last_off;

  always_comb begin
    unique case (mode)
      ORD_TOGGLE: begin
        word_addr = f_toggle(base_word, count);
        at_last   = blk_last;
      end
      ORD_WRAP: begin
        word_addr = f_wrap(base_word, count, line_mask);
        at_last   = blk_last;
      end
      default: begin
        word_addr = f_linear(base_word, count);
        at_last   = lin_last;
      end
    endcase
  end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import bseq_pkg::*;
#(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned CFG_W    = 8,
  parameter int unsigned MIN_LINE = 4,
  parameter int unsigned N_SIZES  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-3:0] start_word,
  input  logic [1:0]        order_mode,
  input  logic [CFG_W-1:0]  line_words,
  input  logic              wide,
  input  logic              coherent,
  input  logic              phase_done,
  output logic [ADDR_W-1:0] addr,
  output logic              active,
  output logic              disconnect,
  output logic              single_only,
  output logic              align_err
);
  localparam int unsigned WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] base_q;
  order_e            mode_q;
  logic [WORD_W-1:0] mask_q;
  logic              single_q;
  logic              wide_q;
  logic              coh_q;
  logic              active_q;
  logic              align_q;

  logic [WORD_W-1:0] dec_mask;
  logic              dec_ok;
  logic [WORD_W-1:0] count;
  logic [WORD_W-1:0] word_addr;
  logic              at_last;

  // named events for the checker
  logic adv_evt;
  logic lin_sel;
  logic misalign_evt;

  bseq_line_decode #(
    .CFG_W(CFG_W), .WORD_W(WORD_W), .MIN_LINE(MIN_LINE), .N_SIZES(N_SIZES)
  ) u_dec (
    .line_words(line_words),
    .line_mask (dec_mask),
    .supported (dec_ok)
  );

  assign misalign_evt = wide & start_word[0];
  assign adv_evt      = active_q & phase_done & ~load;
  assign lin_sel      = (mode_q == ORD_LINEAR) || (mode_q == ORD_LINEAR_ALT);
  assign disconnect   = active_q & (single_q | (coh_q & at_last));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q   <= '0;
      mode_q   <= ORD_LINEAR;
      mask_q   <= '0;
      single_q <= 1'b0;
      wide_q   <= 1'b0;
      coh_q    <= 1'b0;
      active_q <= 1'b0;
      align_q  <= 1'b0;
    end else if (load) begin
      base_q   <= start_word;
      mode_q   <= order_e'(order_mode);
      mask_q   <= dec_mask;
      single_q <= ~dec_ok;
      wide_q   <= wide;
      coh_q    <= coherent;
      active_q <= ~misalign_evt;
      align_q  <= misalign_evt;
    end else if (adv_evt && disconnect) begin
      active_q <= 1'b0;
    end
  end

  bseq_phase_counter #(.W(WORD_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (load),
    .step_en (adv_evt & ~disconnect),
    .step_two(wide_q),
    .count   (count)
  );

  bseq_addr_calc #(.WORD_W(WORD_W)) u_calc (
    .base_word(base_q),
    .count    (count),
    .line_mask(mask_q),
    .mode     (mode_q),
    .wide     (wide_q),
    .word_addr(word_addr),
    .at_last  (at_last)
  );

  assign addr        = {word_addr, 2'b00};
  assign active      = active_q;
  assign single_only = single_q;
  assign align_err   = align_q;
endmodule

// File: rtl/bseq_chk.sv
module bseq_chk #(
  parameter int unsigned ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              load,
  input logic              phase_done,
  input logic [ADDR_W-3:0] start_word,
  input logic [ADDR_W-1:0] addr,
  input logic              active,
  input logic              disconnect,
  input logic              single_only,
  input logic              align_err,
  input logic              adv_evt,
  input logic              lin_sel,
  input logic              wide_q
);
  // R2
  load_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> addr == {$past(start_word), 2'b00});

  // R7
  burst_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && phase_done && disconnect && !load) |=> !active);

  // R10
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !(active && phase_done)) |=> $stable(addr));

  // R3
  linear_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lin_sel && adv_evt && !disconnect) |=>
      addr == $past(addr) + ($past(wide_q) ? ADDR_W'(8) : ADDR_W'(4)));

  // R9
  align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    align_err |-> !active);

  // R6
  single_disc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (single_only && active) |-> disconnect);
endmodule

bind burst_addr_seq bseq_chk #(.ADDR_W(ADDR_W)) u_bseq_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .load       (load),
  .phase_done (phase_done),
  .start_word (start_word),
  .addr       (addr),
  .active     (active),
  .disconnect (disconnect),
  .single_only(single_only),
  .align_err  (align_err),
  .adv_evt    (adv_evt),
  .lin_sel    (lin_sel),
  .wide_q     (wide_q)
);

// File: tb/tb_burst_addr_seq.sv
`timescale 1ns/1ps
module tb_burst_addr_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load = 1'b0;
  logic [29:0] start_word = '0;
  logic [1:0]  order_mode = 2'b00;
  logic [7:0]  line_words = 8'd8;
  logic        wide = 1'b0;
  logic        coherent = 1'b0;
  logic        phase_done = 1'b0;
  logic [31:0] addr;
  logic        active;
  logic        disconnect;
  logic        single_only;
  logic        align_err;

  int n_cmp = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  burst_addr_seq dut (
    .clk(clk), .rst_n(rst_n), .load(load), .start_word(start_word),
    .order_mode(order_mode), .line_words(line_words), .wide(wide),
    .coherent(coherent), .phase_done(phase_done), .addr(addr),
    .active(active), .disconnect(disconnect), .single_only(single_only),
    .align_err(align_err)
  );

  typedef struct packed {
    logic [3:0]  req;
    logic [1:0]  mode;
    logic [7:0]  line;
    logic        wd;
    logic        coh;
    logic [29:0] start;
    logic [7:0]  n;
    logic [31:0] exp_addr;
    logic        exp_act;
    logic        exp_disc;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{4'd3,  2'd0, 8'd8,  1'b0, 1'b0, 30'h40,  8'd3,  32'h10C,  1'b1, 1'b0}, // R3 linear
    '{4'd3,  2'd0, 8'd8,  1'b1, 1'b0, 30'h40,  8'd3,  32'h118,  1'b1, 1'b0}, // R3 wide
    '{4'd4,  2'd1, 8'd8,  1'b0, 1'b0, 30'h1003,8'd4,  32'h401C, 1'b1, 1'b0}, // R4 toggle
    '{4'd4,  2'd1, 8'd8,  1'b1, 1'b0, 30'h1002,8'd3,  32'h4010, 1'b1, 1'b0}, // R4 wide
    '{4'd5,  2'd2, 8'd4,  1'b0, 1'b0, 30'h1002,8'd2,  32'h4000, 1'b1, 1'b0}, // R5 wrap back
    '{4'd5,  2'd2, 8'd4,  1'b0, 1'b0, 30'h1002,8'd4,  32'h4018, 1'b1, 1'b0}, // R5 next line
    '{4'd5,  2'd2, 8'd16, 1'b0, 1'b0, 30'h805, 8'd12, 32'h2004, 1'b1, 1'b0}, // R5 16 words
    '{4'd11, 2'd3, 8'd8,  1'b0, 1'b0, 30'h80,  8'd2,  32'h208,  1'b1, 1'b0}, // R11 alias
    '{4'd5,  2'd2, 8'd8,  1'b0, 1'b0, 30'hC01, 8'd8,  32'h3024, 1'b1, 1'b0}, // R5 8 words
    '{4'd7,  2'd0, 8'd4,  1'b1, 1'b1, 30'h0,   8'd1,  32'h8,    1'b1, 1'b1}, // R7 wide
    '{4'd8,  2'd1, 8'd4,  1'b0, 1'b1, 30'h1003,8'd3,  32'h4000, 1'b1, 1'b1}, // R8 toggle
    '{4'd8,  2'd2, 8'd8,  1'b0, 1'b1, 30'hC01, 8'd7,  32'h3000, 1'b1, 1'b1}  // R8 wrap
  };

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic do_load(input logic [1:0] m, input logic [7:0] l, input logic w,
                         input logic c, input logic [29:0] s);
    @(negedge clk);
    order_mode = m; line_words = l; wide = w; coherent = c; start_word = s;
    load = 1'b1;
    @(negedge clk);
    load = 1'b0;
  endtask

  task automatic do_phases(input int n);
    for (int i = 0; i < n; i++) begin
      phase_done = 1'b1;
      @(negedge clk);
    end
    phase_done = 1'b0;
  endtask

  initial begin
    #(5.0 * 100000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "addr", addr, 32'h0);
    check("R1", "active", {31'b0, active}, 32'h0);
    check("R1", "flags", {29'b0, disconnect, single_only, align_err}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      do_load(VECS[v].mode, VECS[v].line, VECS[v].wd, VECS[v].coh, VECS[v].start);
      do_phases(int'(VECS[v].n));
      check($sformatf("R%0d", VECS[v].req), "addr", addr, VECS[v].exp_addr);
      check($sformatf("R%0d", VECS[v].req), "active", {31'b0, active}, {31'b0, VECS[v].exp_act});
      check($sformatf("R%0d", VECS[v].req), "disconnect", {31'b0, disconnect}, {31'b0, VECS[v].exp_disc});
    end

    // R2 load value and R7 unaligned coherent burst end
    do_load(2'd0, 8'd4, 1'b0, 1'b1, 30'h41);
    check("R2", "addr", addr, 32'h104);
    check("R2", "active", {31'b0, active}, 32'h1);
    do_phases(2);
    check("R7", "addr", addr, 32'h10C);
    check("R7", "disconnect", {31'b0, disconnect}, 32'h1);
    do_phases(1);
    check("R7", "active", {31'b0, active}, 32'h0);
    check("R7", "addr", addr, 32'h10C);
    check("R7", "disconnect", {31'b0, disconnect}, 32'h0);
    do_phases(2);
    check("R10", "addr idle phase", addr, 32'h10C);

    // R10 no phase, no move
    do_load(2'd0, 8'd8, 1'b0, 1'b0, 30'h50);
    repeat (3) @(negedge clk);
    check("R10", "addr", addr, 32'h140);

    // R2 restart during a running burst
    do_phases(2);
    do_load(2'd0, 8'd8, 1'b0, 1'b0, 30'h7);
    check("R2", "restart addr", addr, 32'h1C);

    // R6 unsupported line sizes
    do_load(2'd0, 8'd6, 1'b0, 1'b0, 30'h90);
    check("R6", "single_only", {31'b0, single_only}, 32'h1);
    check("R6", "disconnect", {31'b0, disconnect}, 32'h1);
    do_phases(1);
    check("R6", "active", {31'b0, active}, 32'h0);
    check("R6", "addr", addr, 32'h240);
    do_load(2'd2, 8'd32, 1'b0, 1'b0, 30'h90);
    check("R6", "single_only 32", {31'b0, single_only}, 32'h1);
    do_load(2'd0, 8'd16, 1'b0, 1'b0, 30'h90);
    check("R6", "single_only 16", {31'b0, single_only}, 32'h0);

    // R9 misaligned wide start
    do_load(2'd0, 8'd8, 1'b1, 1'b0, 30'h41);
    check("R9", "align_err", {31'b0, align_err}, 32'h1);
    check("R9", "active", {31'b0, active}, 32'h0);
    do_phases(1);
    check("R9", "addr", addr, 32'h104);

    // R8 toggle burst ends after the line
    do_load(2'd1, 8'd4, 1'b0, 1'b1, 30'h1003);
    do_phases(4);
    check("R8", "active", {31'b0, active}, 32'h0);
    check("R8", "addr", addr, 32'h4000);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule